// File: doc/BRIEF.md
# Tag-Bit Framed UART Transmitter

This block is a serial transmitter driven by a master clock that runs at sixteen times the bit rate. A host places a byte on `din` and pulses the active-low strobe `wr_n`. The byte is taken on the strobe's trailing edge, after the strobe has been synchronized into the clock domain, and is held in a one-byte hold register. On the next bit-rate tick with the line free, the byte moves into a shift register and goes out on `tx` as one frame. The frame is a low start bit, eight data bits least significant first, one parity bit and a high stop bit.

The shift register carries two extra marker bits above the data. It fills with zeros from the top as it shifts. The frame position is read straight from the register's contents: one pattern marks the parity slot and all-zero marks the end. The block therefore needs no bit counter. `tx_ready` reports that the hold register is empty and can take another byte. `odd_par` picks odd parity (1) or even parity (0) and is sampled when a byte is loaded.

Top module: `uart_tag_tx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tx` is 1 and `tx_ready` is 1.
- R2: `din` is captured on the rising edge of `wr_n`. `tx_ready` is still at its previous value at the second clock edge after that rise and is 0 after the third edge. From then on, `tx_ready` is 0 exactly while a byte waits in the hold register.
- R3: A frame on `tx` is one start bit of 0, then data bits 0 to 7 in that order, then the parity bit, then a stop bit of 1. Each bit lasts 16 clock cycles.
- R4: The parity bit equals `odd_par` XOR the XOR of the eight data bits. `odd_par` is sampled at load: 1 gives an odd count of ones over data plus parity, 0 gives an even count.
- R5: `tx_ready` returns to 1 on the same clock edge that drives the start bit onto `tx`.
- R6: When the next byte is already waiting, its start bit begins exactly 176 cycles after the previous start bit, so exactly one stop bit separates the two frames.
- R7: A second write while the hold register is still full replaces the waiting byte. Only the later byte is sent.
- R8: With no byte to send, `tx` stays at 1.
- R9: `tx` changes only on a bit-rate tick. With N counted as the number of clock edges since reset was released, that tick is the edge where N is a multiple of 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 16 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low; the byte is taken on its rising edge |
| din | input | DATA_W | Byte to send; must stay stable until three clock edges after `wr_n` rises |
| odd_par | input | 1 | Parity select: 1 odd, 0 even |
| tx | output | 1 | Serial line output, 1 when idle |
| tx_ready | output | 1 | Hold register empty |

## Verification
The hardest states to reach from the ports involve the hold register and the shift register being busy at the same time. A byte must be waiting when the stop bit ends, and a second write must land while a byte is still waiting. To get there, the stimulus writes the next byte as soon as `tx_ready` rises, which keeps the hold register full across every frame boundary. This is done in a sweep of all 256 values under each parity mode, and the start-to-start distance is then measured. A separate sequence writes three bytes in quick succession while the first is on the line, and expects only the first and third to come out.

// File: rtl/uart_tag_tx.sv
module uart_tag_tx #(
  parameter int DATA_W  = 8,
  parameter int OS_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  input  logic              odd_par,
  output logic              tx,
  output logic              tx_ready
);
  localparam int FR_W = DATA_W + 2;

  logic [2:0]         wr_sync;
  logic               wr_edge;
  logic [DATA_W-1:0]  hold;
  logic               hold_full;
  logic [OS_LOG2-1:0] baud_cnt;
  logic               tick;
  logic [FR_W-1:0]    shreg;
  logic               par;
  logic               done;
  logic               par_cycle;
  logic               load;

  assign wr_edge   = wr_sync[1] & ~wr_sync[2];
  assign tick      = &baud_cnt;
  assign done      = ~|shreg;
  assign par_cycle = shreg[1] & ~|shreg[FR_W-1:2];
  assign load      = tick & done & hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sync   <= '1;
      hold      <= '0;
      hold_full <= 1'b0;
      tx_ready  <= 1'b1;
      baud_cnt  <= '0;
      shreg     <= '0;
      par       <= 1'b0;
      tx        <= 1'b1;
    end else begin
      wr_sync   <= {wr_sync[1:0], wr_n};
      baud_cnt  <= baud_cnt + 1'b1;
      if (wr_edge) hold <= din;
      hold_full <= wr_edge | (hold_full & ~load);
      tx_ready  <= ~wr_edge & (tx_ready | load);
      if (tick) begin
        if (load) begin
          shreg <= {2'b10, hold};
          par   <= odd_par;
          tx    <= 1'b0;
        end else begin
          shreg <= {1'b0, shreg[FR_W-1:1]};
          par   <= par ^ shreg[0];
          tx    <= done ? 1'b1 : (par_cycle ? par : shreg[0]);
        end
      end
    end
  end
endmodule

// File: rtl/uart_tag_tx_chk.sv
module uart_tag_tx_chk #(
  parameter int CNT_W = 4,
  parameter int FR_W  = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             tx,
  input logic             tx_ready,
  input logic [CNT_W-1:0] cnt,
  input logic             full,
  input logic [FR_W-1:0]  frame
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx && tx_ready));

  // R2
  ready_full_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready != full);

  // R5
  ready_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> !tx);

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (frame == '0) |-> tx);

  // R9
  tick_align_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx) |-> $past(&cnt));
endmodule

bind uart_tag_tx uart_tag_tx_chk #(.CNT_W(OS_LOG2), .FR_W(DATA_W + 2)) u_chk (
  .clk(clk), .rst(rst), .tx(tx), .tx_ready(tx_ready),
  .cnt(baud_cnt), .full(hold_full), .frame(shreg)
);

// File: tb/uart_tag_tx_tb.sv
`timescale 1ns/1ps
module uart_tag_tx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic odd_par = 1'b0;
  logic tx, tx_ready;

  always #2.5 clk = ~clk;

  uart_tag_tx u_dut (.clk(clk), .rst(rst), .wr_n(wr_n), .din(din),
                     .odd_par(odd_par), .tx(tx), .tx_ready(tx_ready));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wi = 0;
  int ri = 0;
  int last_start = 0;
  logic [7:0] exp_d [0:1023];
  logic       exp_p [0:1023];
  logic       exp_b2b [0:1023];

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Serial monitor: samples each bit at its centre.
  initial begin
    logic [7:0] d;
    logic p;
    forever begin
      @(negedge clk);
      if (!rst && tx == 1'b0) begin
        chk(cyc % 16 == 0, "R9 start on tick", cyc % 16, 0);
        chk(tx_ready == 1'b1, "R5 ready with start", tx_ready, 1);
        if (ri < wi && exp_b2b[ri])
          chk(cyc - last_start == 176, "R6 start spacing", cyc - last_start, 176);
        last_start = cyc;
        repeat (8) @(negedge clk);
        chk(tx == 1'b0, "R3 start bit", tx, 0);
        for (int k = 0; k < 8; k++) begin
          repeat (16) @(negedge clk);
          d[k] = tx;
        end
        repeat (16) @(negedge clk);
        p = tx;
        repeat (16) @(negedge clk);
        chk(tx == 1'b1, "R3 stop bit", tx, 1);
        if (ri < wi) begin
          chk(d == exp_d[ri], "R3 R7 data", d, exp_d[ri]);
          chk(p == exp_p[ri], "R4 parity", p, exp_p[ri]);
        end else begin
          chk(1'b0, "R3 unexpected frame", d, 0);
        end
        ri++;
      end
    end
  end

  task automatic do_write(input logic [7:0] v, input bit first, input bit push,
                          input logic ready_before);
    @(negedge clk);
    din  = v;
    wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_ready == ready_before, "R2 ready before capture", tx_ready, ready_before);
    @(negedge clk);
    chk(tx_ready == 1'b0, "R2 ready after capture", tx_ready, 0);
    if (push) begin
      exp_d[wi]   = v;
      exp_p[wi]   = odd_par ^ (^v);
      exp_b2b[wi] = !first;
      wi++;
    end
    @(negedge clk);
    din = ~v;
  endtask

  task automatic wait_drain();
    while (ri != wi) @(negedge clk);
  endtask

  task automatic idle_check(input int n);
    bit ok = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (tx !== 1'b1) ok = 1'b0;
    end
    chk(ok, "R8 idle line high", ok, 1);
  endtask

  task automatic sweep(input logic mode);
    odd_par = mode;
    for (int i = 0; i < 256; i++) begin
      while (tx_ready !== 1'b1) @(negedge clk);
      do_write(i[7:0], i == 0, 1'b1, 1'b1);
    end
    wait_drain();
    idle_check(64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx == 1'b1, "R1 tx in reset", tx, 1);
    chk(tx_ready == 1'b1, "R1 ready in reset", tx_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(tx == 1'b1 && tx_ready == 1'b1, "R1 after reset", {tx, tx_ready}, 3);
    idle_check(100);
    sweep(1'b0);
    sweep(1'b1);
    // R7: overwrite of a waiting byte
    do_write(8'hA5, 1'b1, 1'b1, 1'b1);
    while (tx_ready !== 1'b1) @(negedge clk);
    do_write(8'h3C, 1'b0, 1'b0, 1'b1);
    do_write(8'hC3, 1'b0, 1'b1, 1'b0);
    wait_drain();
    idle_check(200);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d frames", ri, wi);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule